// File: doc/BRIEF.md
# Self-Clearing Pulse Reset Controller

This block is a board-management register that drives six peripheral reset lines. A management controller reaches it over a simple byte-wide register port, with a write strobe, a read strobe, an 8-bit address and 8-bit data in each direction. The control byte sits at address 0x10. Each of its six channel bits drives one active-low reset output. The other two bits of the byte are not wired to any output.

To reset a peripheral, software writes 0 to that channel's bit. The output goes low at once and stays low for a fixed number of clock cycles, `PULSE_CYCLES`. The block then returns the bit to 1 by itself. While the pulse runs, the bit reads back as 0, so software can poll the byte until the bit reads 1 again. The block has no way to hold a line in reset, and no separate release command.

Each channel times its own pulse. Pulses started at different times therefore end at different times. The default pulse of 1000 cycles lasts a few microseconds at usual clock rates. This is far below the 125 ms limit that polling software allows.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: After power-on reset, the control byte at 0x10 reads 0xFF and all six reset outputs are high.
- R2: Channels 0 to 5 map to bits 0, 1, 2, 4, 6 and 7 of the control byte. Writing a byte to 0x10 with a channel's bit at 0 drives that channel's output low from the next cycle, and the bit reads 0.
- R3: A started pulse keeps the output low for exactly `PULSE_CYCLES` clock cycles. It then returns to high, and the bit returns to 1, without any further write.
- R4: Each channel times its pulse independently. Starting or ending one channel's pulse does not change any other channel.
- R5: Writing 0 to a channel whose pulse is running restarts that channel's full pulse length from the new write.
- R6: Writing 1 to a channel bit has no effect. Bits 3 and 5 ignore writes and always read as 1.
- R7: A read at any address other than 0x10 returns 0x00. A write to any address other than 0x10 changes no output and no bit.
- R8: Read data appears on `rdata_o` one cycle after the read strobe. It holds its value until the next read strobe.
- R9: Each reset output always equals its channel bit in the control byte: low while the bit is 0, high while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_en_i` |
| periph_rst_no | output | 6 | Active-low reset outputs, channel 0 at bit 0 |

## Verification
The assertions assume a few things about the inputs. The strobes, address and write data must be known and steady at every rising edge. `PULSE_CYCLES` must be at least 2, so that the pulse counter and the cycle-count checker have room to count. A read and a write in the same cycle are allowed: the read returns the byte as it stood before the write. The bench drives every input on the falling edge. It uses a pulse length of 20 cycles so that complete pulses, overlapping pulses and restarts all fit in a short run. A reference model counts down the remaining pulse cycles per channel and is compared with the design on every cycle.

// File: rtl/rst_pulse_pkg.sv
package rst_pulse_pkg;
  localparam int unsigned NUM_CH = 6;
  localparam int unsigned BUS_W  = 8;
  // register bit that carries each channel; fixed by software decode
  localparam int unsigned CH_BIT [NUM_CH] = '{0, 1, 2, 4, 6, 7};
  localparam logic [BUS_W-1:0] CTRL_ADDR = 8'h10;
endpackage

// File: rtl/rst_pulse_timer.sv
module rst_pulse_timer #(
  parameter int unsigned PULSE_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  // cycle-age checker, independent of the down counter
  logic [CNT_W:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      age_q <= '0;
    else if (start_i) age_q <= '0;
    else if (busy_q)  age_q <= age_q + 1'b1;
  end

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q); // R2
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (busy_q && age_q == '0)); // R5
  AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (age_q < (CNT_W+1)'(PULSE_CYCLES))); // R3
  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (age_q == (CNT_W+1)'(PULSE_CYCLES))); // R3
endmodule

// File: rtl/rst_pulse_regport.sv
module rst_pulse_regport
  import rst_pulse_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BUS_W-1:0]  addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [NUM_CH-1:0] busy_i,
  output logic [NUM_CH-1:0] start_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic             hit;
  logic [BUS_W-1:0] ctrl_val;
  logic [BUS_W-1:0] rdata_q;

  assign hit = (addr_i == CTRL_ADDR);

  always_comb begin
    ctrl_val = '1;
    for (int c = 0; c < NUM_CH; c++) begin
      start_o[c]            = wr_en_i && hit && !wdata_i[CH_BIT[c]];
      ctrl_val[CH_BIT[c]]   = !busy_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= hit ? ctrl_val : '0;
  end

  assign rdata_o = rdata_q;

  AST_MISS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit) |=> (rdata_o == '0)); // R7
  AST_MISS_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (start_o == '0)); // R7
  AST_RSVD_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hit) |=> (rdata_o[3] && rdata_o[5])); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R8
endmodule

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl
  import rst_pulse_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic [5:0]  periph_rst_no
);
  logic [NUM_CH-1:0] start;
  logic [NUM_CH-1:0] busy;

  rst_pulse_regport u_regport (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .busy_i  (busy),
    .start_o (start),
    .rdata_o (rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rst_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start[c]),
      .busy_o  (busy[c])
    );
  end

  assign periph_rst_no = ~busy;

  AST_IDLE_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !$fell(periph_rst_no[0])); // R4
  AST_OUT_MATCH_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == CTRL_ADDR) |=>
      (rdata_o[0] == $past(periph_rst_no[0]) && rdata_o[7] == $past(periph_rst_no[5]))); // R9
endmodule

// File: tb/tb_rst_pulse_ctrl.sv
module tb_rst_pulse_ctrl;
  localparam int P = 20;
  localparam int CHB [6] = '{0, 1, 2, 4, 6, 7};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [5:0] rst_n;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  rst_pulse_ctrl #(.PULSE_CYCLES(P)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .periph_rst_no(rst_n)
  );

  // behavioural reference: remaining low cycles per channel
  int rem [6];
  logic [7:0] exp_rd;

  function automatic logic [7:0] model_byte();
    logic [7:0] v = 8'hFF;
    for (int c = 0; c < 6; c++) if (rem[c] > 0) v[CHB[c]] = 1'b0;
    return v;
  endfunction

  function automatic logic [5:0] model_out();
    logic [5:0] v;
    for (int c = 0; c < 6; c++) v[c] = !(rem[c] > 0);
    return v;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 6; c++) rem[c] = 0;
      exp_rd = 8'h00;
    end else begin
      if (rd_en) exp_rd = (addr == 8'h10) ? model_byte() : 8'h00;
      for (int c = 0; c < 6; c++) begin
        if (wr_en && addr == 8'h10 && !wdata[CHB[c]]) rem[c] = P;
        else if (rem[c] > 0) rem[c] = rem[c] - 1;
      end
    end
  end

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check8({cur_req, " R9 outputs"}, {2'b00, rst_n}, {2'b00, model_out()});
      check8({cur_req, " R8 rdata"}, rdata, exp_rd);
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check8("R1 outputs in reset", {2'b00, rst_n}, 8'h3F);
    rst_ni = 1'b1;
    rd(8'h10);
    check8("R1 ctrl byte", rdata, 8'hFF);
    check8("R1 outputs", {2'b00, rst_n}, 8'h3F);

    // R2 each channel individually, R3 full pulse and self-clear
    cur_req = "R2";
    for (int c = 0; c < 6; c++) begin
      wr(8'h10, ~(8'h01 << CHB[c]));
      check8("R2 output low", {2'b00, rst_n}, {2'b00, ~(6'h01 << c)});
      rd(8'h10);
      check8("R2 bit reads 0", rdata, ~(8'h01 << CHB[c]));
      cur_req = "R3";
      idle(P);
      check8("R3 self-cleared", {2'b00, rst_n}, 8'h3F);
      rd(8'h10);
      check8("R3 bit back to 1", rdata, 8'hFF);
      cur_req = "R2";
    end

    // R4 staggered channels
    cur_req = "R4";
    wr(8'h10, 8'hFD);            // ch1
    idle(7);
    wr(8'h10, 8'hBF);            // ch4
    idle(P - 8);
    check8("R4 ch1 done ch4 running", {2'b00, rst_n}, 8'h2F);
    idle(P);

    // R5 restart during pulse
    cur_req = "R5";
    wr(8'h10, 8'hFB);            // ch2
    idle(10);
    wr(8'h10, 8'hFB);
    idle(P - 2);
    check8("R5 still low after restart", {2'b00, rst_n}, 8'h3B);
    idle(3);
    check8("R5 released", {2'b00, rst_n}, 8'h3F);

    // R6 ones and reserved bits
    cur_req = "R6";
    wr(8'h10, 8'hFF);
    wr(8'h10, 8'hD7);            // only bits 3 and 5 zero
    check8("R6 no effect outputs", {2'b00, rst_n}, 8'h3F);
    rd(8'h10);
    check8("R6 reserved read 1", rdata, 8'hFF);
    wr(8'h10, 8'h00);            // all channels
    rd(8'h10);
    check8("R6 reserved stay 1 in pulse", rdata, 8'h28);
    idle(P);

    // R7 other addresses
    cur_req = "R7";
    wr(8'h11, 8'h00);
    wr(8'h00, 8'h00);
    check8("R7 write ignored", {2'b00, rst_n}, 8'h3F);
    rd(8'h11);
    check8("R7 miss reads 0", rdata, 8'h00);
    rd(8'h10);
    rd(8'hFF);
    check8("R7 miss reads 0 again", rdata, 8'h00);

    // R8 hold between strobes
    cur_req = "R8";
    rd(8'h10);
    wr(8'h10, 8'h7F);            // ch5 starts, rdata must hold
    idle(3);
    check8("R8 rdata holds", rdata, 8'hFF);
    rd(8'h10);
    check8("R8 new read", rdata, 8'h7F);
    idle(P);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule